// File: doc/BRIEF.md
# Configurable Dual-Port Block RAM

A behavioural, synthesizable model of an embedded memory with two independent access ports on a 16K-bit store. The store grows to 18K bits when either port is built 9 or 18 bits wide. Each port gets its own data width at build time, and the width sets how many address bits the port uses. Each port also has its own clock enable, synchronous reset, write enable, 3-bit select code, 14-bit address, and 18-bit data in and out.

Per-port parameters set three things. The first is the select code the port answers to. The second is what the port's output shows on a write cycle: it holds, it shows the new data, or it shows the data that was overwritten. The third is whether a second output register is added, which moves read latency from one cycle to two. Both ports address the same bits. A word of width W at address N occupies bits N*W up to N*W+W-1, so ports of different widths see the same contents. Both ports run from the single clock input `clk`.

Top module: `dual_port_bram`

## Requirements
- R1: A port's width must be one of 1, 2, 4, 9 or 18, and it then uses 14, 13, 12, 11 or 10 address bits. Any other width stops elaboration.
- R2: On a port without the output register, the word read by an accepted request appears on the read-data output just after the clock edge that samples the request.
- R3: On a port with the output register, read data appears one clock edge later than in R2.
- R4: A request is accepted only when its clock enable is 1 and its select input equals the port's select parameter. A request that is not accepted leaves the memory and that port's output unchanged.
- R5: In hold mode (mode code 0), an accepted write leaves the port's first output stage unchanged.
- R6: In new-data mode (mode code 1), an accepted write places the written word on the port's output.
- R7: In old-data mode (mode code 2), an accepted write places the location's previous contents on the port's output. This mode is legal only at widths 9 and 18, and any other width stops elaboration.
- R8: The two ports must never touch overlapping bits in the same cycle when either of them writes. A simulation assertion flags such a collision.
- R9: A word of width W at address N maps to store bits N*W through N*W+W-1, so data written through one port reads back consistently through a port of another width.
- R10: Address bits above the port's address width and data bits above the port's width are ignored. Read-data bits above the port's width are 0.
- R11: A port's synchronous reset clears both of its output stages to 0 at the next clock edge, and both are 0 after power-up reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| a_rst | input | 1 | Port A synchronous output reset, active high |
| a_ce | input | 1 | Port A clock enable |
| a_we | input | 1 | Port A write enable |
| a_sel | input | 3 | Port A select code, matched against A_SEL |
| a_addr | input | 14 | Port A word address, low bits used |
| a_wdata | input | 18 | Port A write data, low bits used |
| a_rdata | output | 18 | Port A read data, zero above the port width |
| b_rst | input | 1 | Port B synchronous output reset, active high |
| b_ce | input | 1 | Port B clock enable |
| b_we | input | 1 | Port B write enable |
| b_sel | input | 3 | Port B select code, matched against B_SEL |
| b_addr | input | 14 | Port B word address, low bits used |
| b_wdata | input | 18 | Port B write data, low bits used |
| b_rdata | output | 18 | Port B read data, zero above the port width |

## Verification
The assertions assume that, in any one cycle, the bit ranges of the two ports never overlap while either port writes. They also assume that reset is held long enough for each output stage to see a clock edge. The stimulus mostly drives one port at a time, so no collision can arise. Its single simultaneous case pairs a write and a read whose bit ranges are far apart. Reset is held for several cycles at the start and pulsed once mid-run.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL  = 2'd0,
    WM_THROUGH = 2'd1,
    WM_OLDDATA = 2'd2
  } wmode_e;

  localparam int PORT_AW = 14;
  localparam int PORT_DW = 18;
  localparam int SEL_W   = 3;

  // Address width for a legal data width; 0 marks an illegal width (R1)
  function automatic int addr_bits(int w);
    case (w)
      1:  return 14;
      2:  return 13;
      4:  return 12;
      9:  return 11;
      18: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic bit width_ok(int w);
    return addr_bits(w) != 0;
  endfunction

  function automatic bit is_wide(int w);
    return (w == 9) || (w == 18);
  endfunction

  // Store size: widths carrying the extra bit per byte need the larger store
  function automatic int array_bits(int wa, int wb);
    return (is_wide(wa) || is_wide(wb)) ? 18432 : 16384;
  endfunction

  // First store bit of word n at width w (R9)
  function automatic int word_base(int n, int w);
    return n * w;
  endfunction

  function automatic bit spans_overlap(int ba, int wa, int bb, int wb);
    return (ba < bb + wb) && (bb < ba + wa);
  endfunction

endpackage

// File: rtl/dpram_port_front.sv
module dpram_port_front
  import dpram_pkg::*;
#(
  parameter int         W    = 18,
  parameter logic [2:0] SEL  = 3'd0,
  parameter int         IDXW = 15
) (
  input  logic                ce,
  input  logic [SEL_W-1:0]    sel,
  input  logic                we,
  input  logic [PORT_AW-1:0]  addr,
  input  logic [PORT_DW-1:0]  wdata,
  output logic                acc,
  output logic                wr,
  output logic [IDXW-1:0]     base,
  output logic [W-1:0]        wd
);
  localparam int AW = addr_bits(W);

  generate
    if (!width_ok(W)) begin : g_bad_width
      $error("dpram_port_front: data width %0d is not 1, 2, 4, 9 or 18", W);
    end
  endgenerate

  logic [AW-1:0] word;
  logic          unused_ok;

  assign word      = addr[AW-1:0];
  assign wd        = wdata[W-1:0];
  assign unused_ok = &{1'b0, addr, wdata};

  assign acc  = ce && (sel == SEL);
  assign wr   = acc && we;
  assign base = IDXW'(word_base(int'(word), W));

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
  import dpram_pkg::*;
#(
  parameter int     W      = 18,
  parameter bit     OUTREG = 1'b0,
  parameter wmode_e MODE   = WM_NORMAL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc,
  input  logic               wr,
  input  logic [W-1:0]       wd,
  input  logic [W-1:0]       old,
  output logic [PORT_DW-1:0] rdata
);
  generate
    if (MODE == WM_OLDDATA && !is_wide(W)) begin : g_bad_mode
      $error("dpram_port_out: old-data mode needs width 9 or 18, got %0d", W);
    end
  endgenerate

  logic [W-1:0] st1;
  logic [W-1:0] q;

  // First stage: address and data were registered with this same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      st1 <= '0;
    end else if (acc) begin
      if (!wr) begin
        st1 <= old;
      end else begin
        case (MODE)
          WM_THROUGH: st1 <= wd;
          WM_OLDDATA: st1 <= old;
          default:    st1 <= st1;
        endcase
      end
    end
  end

  generate
    if (OUTREG) begin : g_outreg
      logic [W-1:0] st2;
      always_ff @(posedge clk) begin
        if (rst) st2 <= '0;
        else     st2 <= st1;
      end
      assign q = st2;
    end else begin : g_direct
      assign q = st1;
    end
  endgenerate

  always_comb begin
    rdata        = '0;
    rdata[W-1:0] = q;
  end

  // ---------------- assertions ----------------
  AST_RST_CLEARS: assert property (@(posedge clk) $fell(rst) |-> (q == '0)); // R11

  generate
    if (MODE == WM_NORMAL) begin : g_chk_hold
      AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr |=> $stable(st1)); // R5
    end
    if (MODE == WM_THROUGH && !OUTREG) begin : g_chk_thr1
      AST_THROUGH_ONE: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == $past(wd))); // R6
    end
    if (MODE == WM_THROUGH && OUTREG) begin : g_chk_thr2
      AST_THROUGH_TWO: assert property (@(posedge clk) disable iff (rst)
        wr |=> ##1 (q == $past(wd, 2))); // R6
    end
    if (MODE == WM_OLDDATA && !OUTREG) begin : g_chk_old1
      AST_OLDDATA_ONE: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == $past(old))); // R7
    end
    if (MODE == WM_OLDDATA && OUTREG) begin : g_chk_old2
      AST_OLDDATA_TWO: assert property (@(posedge clk) disable iff (rst)
        wr |=> ##1 (q == $past(old, 2))); // R7
    end
  endgenerate

endmodule

// File: rtl/dual_port_bram.sv
module dual_port_bram
  import dpram_pkg::*;
#(
  parameter int         A_W      = 18,
  parameter int         B_W      = 18,
  parameter bit         A_OUTREG = 1'b0,
  parameter bit         B_OUTREG = 1'b0,
  parameter wmode_e     A_MODE   = WM_NORMAL,
  parameter wmode_e     B_MODE   = WM_NORMAL,
  parameter logic [2:0] A_SEL    = 3'd0,
  parameter logic [2:0] B_SEL    = 3'd0
) (
  input  logic        clk,
  input  logic        a_rst,
  input  logic        a_ce,
  input  logic        a_we,
  input  logic [2:0]  a_sel,
  input  logic [13:0] a_addr,
  input  logic [17:0] a_wdata,
  output logic [17:0] a_rdata,
  input  logic        b_rst,
  input  logic        b_ce,
  input  logic        b_we,
  input  logic [2:0]  b_sel,
  input  logic [13:0] b_addr,
  input  logic [17:0] b_wdata,
  output logic [17:0] b_rdata
);
  localparam int MEM_BITS = array_bits(A_W, B_W);
  localparam int IDXW     = $clog2(MEM_BITS);

  logic [MEM_BITS-1:0] mem;

  logic            a_acc, a_wr, b_acc, b_wr;
  logic [IDXW-1:0] a_base, b_base;
  logic [A_W-1:0]  a_wd, a_old;
  logic [B_W-1:0]  b_wd, b_old;

  dpram_port_front #(.W(A_W), .SEL(A_SEL), .IDXW(IDXW)) u_front_a (
    .ce(a_ce), .sel(a_sel), .we(a_we), .addr(a_addr), .wdata(a_wdata),
    .acc(a_acc), .wr(a_wr), .base(a_base), .wd(a_wd)
  );

  dpram_port_front #(.W(B_W), .SEL(B_SEL), .IDXW(IDXW)) u_front_b (
    .ce(b_ce), .sel(b_sel), .we(b_we), .addr(b_addr), .wdata(b_wdata),
    .acc(b_acc), .wr(b_wr), .base(b_base), .wd(b_wd)
  );

  // Shared store: a write covers bits base .. base+W-1 (R9)
  always_ff @(posedge clk) begin
    if (a_wr) mem[a_base +: A_W] <= a_wd;
    if (b_wr) mem[b_base +: B_W] <= b_wd;
  end

  assign a_old = mem[a_base +: A_W];
  assign b_old = mem[b_base +: B_W];

  dpram_port_out #(.W(A_W), .OUTREG(A_OUTREG), .MODE(A_MODE)) u_out_a (
    .clk(clk), .rst(a_rst), .acc(a_acc), .wr(a_wr),
    .wd(a_wd), .old(a_old), .rdata(a_rdata)
  );

  dpram_port_out #(.W(B_W), .OUTREG(B_OUTREG), .MODE(B_MODE)) u_out_b (
    .clk(clk), .rst(b_rst), .acc(b_acc), .wr(b_wr),
    .wd(b_wd), .old(b_old), .rdata(b_rdata)
  );

  // ---------------- assertions ----------------
  logic spans_hit;
  assign spans_hit = spans_overlap(int'(a_base), A_W, int'(b_base), B_W);

  AST_NO_COLLISION: assert property (@(posedge clk) disable iff (a_rst || b_rst)
    !(((a_wr && b_acc) || (b_wr && a_acc)) && spans_hit)); // R8

  AST_IDLE_KEEPS_STORE: assert property (@(posedge clk) disable iff (a_rst || b_rst)
    (!a_acc && !b_acc) |=> $stable(mem)); // R4

endmodule

// File: tb/dual_port_bram_test.sv
module dual_port_bram_test;
  import dpram_pkg::*;

  // Port index: 0 = uut A, 1 = uut B, 2 = uut2 A, 3 = uut2 B
  localparam int WID  [4] = '{4, 18, 9, 2};
  localparam int REGD [4] = '{0, 1, 1, 0};
  localparam int MODE [4] = '{1, 2, 0, 0};   // 0 hold, 1 new data, 2 old data
  localparam int SELV [4] = '{5, 2, 0, 7};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst1 = 1'b1;
  logic        rst2 = 1'b1;
  logic        ce  [4];
  logic        we  [4];
  logic [2:0]  sel [4];
  logic [13:0] ad  [4];
  logic [17:0] wd  [4];
  logic [17:0] q   [4];

  dual_port_bram #(
    .A_W(4), .B_W(18), .A_OUTREG(1'b0), .B_OUTREG(1'b1),
    .A_MODE(WM_THROUGH), .B_MODE(WM_OLDDATA), .A_SEL(3'd5), .B_SEL(3'd2)
  ) uut (
    .clk(clk),
    .a_rst(rst1), .a_ce(ce[0]), .a_we(we[0]), .a_sel(sel[0]), .a_addr(ad[0]),
    .a_wdata(wd[0]), .a_rdata(q[0]),
    .b_rst(rst1), .b_ce(ce[1]), .b_we(we[1]), .b_sel(sel[1]), .b_addr(ad[1]),
    .b_wdata(wd[1]), .b_rdata(q[1])
  );

  dual_port_bram #(
    .A_W(9), .B_W(2), .A_OUTREG(1'b1), .B_OUTREG(1'b0),
    .A_MODE(WM_NORMAL), .B_MODE(WM_NORMAL), .A_SEL(3'd0), .B_SEL(3'd7)
  ) uut2 (
    .clk(clk),
    .a_rst(rst2), .a_ce(ce[2]), .a_we(we[2]), .a_sel(sel[2]), .a_addr(ad[2]),
    .a_wdata(wd[2]), .a_rdata(q[2]),
    .b_rst(rst2), .b_ce(ce[3]), .b_we(we[3]), .b_sel(sel[3]), .b_addr(ad[3]),
    .b_wdata(wd[3]), .b_rdata(q[3])
  );

  bit refm [2][18432];
  int expq [4];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Address width from store size over width, computed differently from the RTL
  function automatic int aw_of(int w);
    return $clog2((((w % 9) == 0) ? 18432 : 16384) / w);
  endfunction

  function automatic int refword(int inst, int base, int w);
    int v;
    v = 0;
    for (int i = 0; i < w; i++) v = v | (int'(refm[inst][base + i]) << i);
    return v;
  endfunction

  task automatic check(int p, string tag);
    checks++;
    if (q[p] !== 18'(expq[p])) begin
      fails++;
      $display("FAIL %s port%0d: got %h expected %h", tag, p, q[p], 18'(expq[p]));
    end
  endtask

  // Drive one request and update the reference model at the same time
  task automatic issue(int p, bit w, int addr, int data, bit c, int s);
    int wi, inst, ma, md, base;
    bit acc;
    wi   = WID[p];
    inst = p / 2;
    ma   = addr & ((1 << aw_of(wi)) - 1);
    md   = data & ((1 << wi) - 1);
    base = ma * wi;
    acc  = c && (s == SELV[p]);
    ce[p]  = c;
    we[p]  = w;
    sel[p] = 3'(s);
    ad[p]  = 14'(addr);
    wd[p]  = 18'(data);
    if (acc) begin
      if (!w) expq[p] = refword(inst, base, wi);
      else begin
        if (MODE[p] == 1) expq[p] = md;
        else if (MODE[p] == 2) expq[p] = refword(inst, base, wi);
        for (int i = 0; i < wi; i++) refm[inst][base + i] = md[i];
      end
    end
  endtask

  task automatic idle_all();
    for (int p = 0; p < 4; p++) ce[p] = 1'b0;
  endtask

  task automatic op(int p, bit w, int addr, int data, bit c, int s, string tag);
    @(negedge clk);
    issue(p, w, addr, data, c, s);
    @(negedge clk);
    idle_all();
    if (REGD[p] != 0) @(negedge clk);
    check(p, tag);
  endtask

  task automatic op_ok(int p, bit w, int addr, int data, string tag);
    op(p, w, addr, data, 1'b1, SELV[p], tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      ce[p] = 1'b0; we[p] = 1'b0; sel[p] = '0; ad[p] = '0; wd[p] = '0; expq[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst1 = 1'b0;
    rst2 = 1'b0;
    for (int p = 0; p < 4; p++) check(p, "R11 output zero after reset");

    // uut A (width 4, new-data, direct): fill every address, R6 on each write
    for (int x = 0; x < 4096; x++) op_ok(0, 1'b1, x, (x * 5 + 3) & 15, "R6 new-data write echo");

    // uut B (width 18, registered): read back across widths, R3 and R9
    for (int y = 0; y < 910; y++) op_ok(1, 1'b0, y, 0, "R3/R9 registered wide read");

    // uut B old-data writes, R7
    for (int y = 0; y < 910; y++) op_ok(1, 1'b1, y, (y * 40503 + 677) & 18'h3FFFF, "R7 old-data write");

    // uut A reads all nibbles written through the wide port, R2 and R9
    for (int x = 0; x < 4096; x++) op_ok(0, 1'b0, x, 0, "R2/R9 direct narrow read");

    // R4: wrong select and clock enable low are both ignored
    op(0, 1'b1, 77, 10, 1'b1, 3, "R4 wrong select leaves output");
    op(0, 1'b1, 77, 10, 1'b0, 5, "R4 enable low leaves output");
    op_ok(0, 1'b0, 77, 0, "R4 store unchanged by ignored writes");
    op(1, 1'b0, 3, 0, 1'b1, 6, "R4 wrong select read ignored");

    // R10: high address and data bits dropped, high output bits zero
    op_ok(0, 1'b1, 14'h3000 | 5, 18'h3FFF9, "R10 upper data bits ignored");
    op_ok(0, 1'b0, 5, 0, "R10 upper address bits ignored");
    // R1: top address of the 12-bit address range
    op_ok(0, 1'b1, 4095, 6, "R1 top address write");
    op_ok(0, 1'b0, 4095, 0, "R1 top address read");

    // R8: simultaneous write and read on disjoint bit ranges
    @(negedge clk);
    issue(0, 1'b1, 9, 12, 1'b1, 5);
    issue(1, 1'b0, 500, 0, 1'b1, 2);
    @(negedge clk);
    idle_all();
    check(0, "R8 concurrent write port");
    @(negedge clk);
    check(1, "R8 concurrent read port");

    // R11: mid-run reset clears both stages
    @(negedge clk);
    rst1 = 1'b1;
    @(negedge clk);
    rst1 = 1'b0;
    expq[0] = 0;
    expq[1] = 0;
    check(0, "R11 reset clears direct output");
    check(1, "R11 reset clears registered output");

    // uut2 A (width 9, hold mode, registered): writes leave output, R5
    for (int x = 0; x < 2048; x++) op_ok(2, 1'b1, x, (x * 149 + 7) & 9'h1FF, "R5 hold on write");
    // uut2 B (width 2): reads every word, R9 and R2
    for (int y = 0; y < 8192; y++) op_ok(3, 1'b0, y, 0, "R9 narrow read of wide data");
    for (int y = 0; y < 1024; y++) op_ok(3, 1'b1, y, (y * 3 + 1) & 3, "R5 hold on narrow write");
    for (int x = 0; x < 2048; x++) op_ok(2, 1'b0, x, 0, "R3/R9 registered 9-bit read");

    done = 1'b1;
    finish_run();
  end

endmodule